// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides, for a processor core, whether a breakpoint or a background-debug instruction halts the core in debug mode or turns into an ordinary breakpoint exception. While reset is held it watches an active-low breakpoint pin through a synchronizer. The level seen at the moment reset is released fixes a debug-enable flag, and that flag stays fixed until the next reset.

At run time the block follows per-instruction breakpoint tags through a short prefetch pipeline. A tag is acknowledged only when its instruction leaves the last prefetch stage for execution. A pipeline flush throws away every tag still in the prefetch stages. Operand breakpoints need no tag and always count. With debug enabled, an acknowledged breakpoint, an operand breakpoint or a background instruction raises freeze at the next instruction boundary. Freeze then holds until an external resume pulse. With debug disabled, breakpoints become a one-cycle exception request and the background instruction does nothing.

Two tracking pins report pipeline advances and operand fetches while the core runs. While the core is frozen they carry a serial data-out and a serial data-in line instead.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: The debug-enable flag is loaded on every clock edge at which `rst_n` is low. It takes the inverse of the `bkpt_n_i` level seen SYNC_STAGES clock edges before that edge. It stays constant while `rst_n` is high, so a pin held low at the last reset edge and through the SYNC_STAGES edges before it enables debug mode.
- R2: If `bkpt_n_i` is high at that sample point, debug mode is disabled. Every new reset samples the pin again.
- R3: A low pulse on `bkpt_n_i` covering fewer than SYNC_STAGES+1 of the final reset edges does not enable debug mode.
- R4: A tag presented with `fetch_tag_i` enters stage 0 on a clock edge where `pipe_adv_i` is 1. Each further advance moves it one stage. The tag is acknowledged in the cycle where `pipe_adv_i` is 1, it sits in stage PF_STAGES-1 and `flush_i` is 0.
- R5: A clock edge with `flush_i` at 1 clears the tags in all prefetch stages and loads no new tag. In the same cycle it suppresses the acknowledgement of the last stage, even when `pipe_adv_i` is 1.
- R6: `op_bkpt_i` acts as a breakpoint in every cycle, whatever the tag pipeline holds.
- R7: With debug enabled and not frozen, an entry request (acknowledged tag, operand breakpoint or `bgnd_i`) is remembered. `freeze_o` goes to 1 one cycle after the first clock edge with `boundary_i` at 1 that has a request present or remembered. `exc_req_o` stays 0 throughout.
- R8: With debug disabled, a breakpoint is remembered and `exc_req_o` is 1 for exactly the one cycle after the next edge with `boundary_i` at 1. `bgnd_i` raises neither output, and `freeze_o` never rises.
- R9: While `freeze_o` is 0: `trk0_o` and `trk1_o` are `pipe_adv_i` and `opfetch_i` delayed by one clock, `trk1_oe_o` is 1 and `ser_rx_o` is 0. While `freeze_o` is 1: `trk0_o` is `ser_tx_i`, `trk1_o` is 0, `trk1_oe_o` is 0 and `ser_rx_o` is `trk1_i`.
- R10: A clock edge with `resume_i` at 1 while frozen clears `freeze_o` after that edge. Requests that arrive while frozen are dropped, and `resume_i` has no effect when the core is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bkpt_n_i | input | 1 | Active-low breakpoint pin, asynchronous |
| pipe_adv_i | input | 1 | Prefetch pipeline advances this cycle |
| fetch_tag_i | input | 1 | Breakpoint tag of the word entering stage 0 |
| flush_i | input | 1 | Prefetch pipeline flush |
| op_bkpt_i | input | 1 | Operand breakpoint request |
| opfetch_i | input | 1 | Operand fetch this cycle |
| bgnd_i | input | 1 | Background instruction decoded |
| boundary_i | input | 1 | Instruction boundary this cycle |
| resume_i | input | 1 | Leave debug mode |
| ser_tx_i | input | 1 | Serial data-out from the debug port logic |
| trk1_i | input | 1 | Input level of tracking pin 1 |
| freeze_o | output | 1 | Core halted in debug mode |
| exc_req_o | output | 1 | Breakpoint exception request pulse |
| trk0_o | output | 1 | Tracking pin 0 / serial data-out |
| trk1_o | output | 1 | Tracking pin 1 output value |
| trk1_oe_o | output | 1 | Tracking pin 1 output enable |
| ser_rx_o | output | 1 | Serial data-in toward the debug port logic |

## Verification
The bench builds the block with SYNC_STAGES=3 and PF_STAGES=2. The longer synchronizer means a pin held low for three final reset edges is still too short, which exercises the boundary between an enabled and a disabled capture. The two-stage prefetch pipe keeps flushed and unflushed tags close together. Random phases run under both enable settings and compare every output each cycle with a behavioural queue model. These phases reach flush-versus-advance collisions, requests that wait for a late boundary, and resume pulses outside freeze.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_HALT = 1'b1
   } dbg_mode_e;

   typedef struct packed {
      logic tag_ack;
      logic operand;
      logic bgnd;
   } dbg_req_t;

   function automatic logic any_bkpt(input dbg_req_t r);
      return r.tag_ack | r.operand;
   endfunction

endpackage

// File: rtl/dbg_enable_sample.sv
module dbg_enable_sample #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bkpt_n_i,
   output logic en_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dbg_enable_sample: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          en_q;

   always_ff @(posedge clk) chain_q[0] <= bkpt_n_i;

   for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
      always_ff @(posedge clk) chain_q[k] <= chain_q[k-1];
   end

   // loaded on each reset edge, frozen after release
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= ~chain_q[LAST];
   end

   assign en_o = en_q;

   p_en_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(en_q));

endmodule

// File: rtl/dbg_tag_pipe.sv
module dbg_tag_pipe #(
   parameter int PF_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   input  logic tag_i,
   input  logic flush_i,
   output logic ack_o
);
   localparam int LAST = PF_STAGES - 1;

   if (PF_STAGES < 1 || PF_STAGES > 8) begin : g_bad_depth
      $error("dbg_tag_pipe: PF_STAGES must be in 1..8");
   end

   logic [LAST:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                tag_q[0] <= 1'b0;
      else if (flush_i)          tag_q[0] <= 1'b0;
      else if (adv_i)            tag_q[0] <= tag_i;
   end

   for (genvar k = 1; k < PF_STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)             tag_q[k] <= 1'b0;
         else if (flush_i)       tag_q[k] <= 1'b0;
         else if (adv_i)         tag_q[k] <= tag_q[k-1];
      end
   end

   // last prefetch stage hands over to execute: acknowledge unless flushed
   assign ack_o = adv_i & tag_q[LAST] & ~flush_i;

   p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (tag_q == '0));

endmodule

// File: rtl/dbg_freeze_ctl.sv
module dbg_freeze_ctl
   import dbg_entry_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en_i,
   input  dbg_req_t req_i,
   input  logic     boundary_i,
   input  logic     resume_i,
   output logic     freeze_o,
   output logic     exc_o
);
   dbg_mode_e mode_q;
   logic      pend_dbg_q, pend_exc_q, exc_q;
   logic      want_dbg, want_exc, take_dbg, take_exc;

   always_comb begin
      want_dbg = en_i & (mode_q == MODE_RUN) & (any_bkpt(req_i) | req_i.bgnd);
      want_exc = ~en_i & any_bkpt(req_i);
      take_dbg = (mode_q == MODE_RUN) & boundary_i & (pend_dbg_q | want_dbg);
      take_exc = boundary_i & (pend_exc_q | want_exc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= MODE_RUN;
         pend_dbg_q <= 1'b0;
         pend_exc_q <= 1'b0;
         exc_q      <= 1'b0;
      end else begin
         exc_q      <= take_exc;
         pend_exc_q <= take_exc ? 1'b0 : (pend_exc_q | want_exc);
         unique case (mode_q)
            MODE_RUN: begin
               mode_q     <= take_dbg ? MODE_HALT : MODE_RUN;
               pend_dbg_q <= take_dbg ? 1'b0 : (pend_dbg_q | want_dbg);
            end
            MODE_HALT: begin
               mode_q     <= resume_i ? MODE_RUN : MODE_HALT;
               pend_dbg_q <= 1'b0;
            end
            default: mode_q <= MODE_RUN;
         endcase
      end
   end

   assign freeze_o = (mode_q == MODE_HALT);
   assign exc_o    = exc_q;

   p_freeze_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && !$past(freeze_o)) |-> $past(boundary_i));
   p_no_exc_when_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> !exc_o);
   p_no_freeze_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !freeze_o);
   p_resume_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && resume_i) |=> !freeze_o);

endmodule

// File: rtl/dbg_track_mux.sv
module dbg_track_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze_i,
   input  logic adv_i,
   input  logic opfetch_i,
   input  logic ser_tx_i,
   input  logic trk1_i,
   output logic trk0_o,
   output logic trk1_o,
   output logic trk1_oe_o,
   output logic ser_rx_o
);
   logic adv_q, of_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adv_q <= 1'b0;
         of_q  <= 1'b0;
      end else begin
         adv_q <= adv_i;
         of_q  <= opfetch_i;
      end
   end

   always_comb begin
      if (freeze_i) begin
         trk0_o    = ser_tx_i;
         trk1_o    = 1'b0;
         trk1_oe_o = 1'b0;
         ser_rx_o  = trk1_i;
      end else begin
         trk0_o    = adv_q;
         trk1_o    = of_q;
         trk1_oe_o = 1'b1;
         ser_rx_o  = 1'b0;
      end
   end

   p_serial_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze_i |-> (ser_rx_o == 1'b0) && trk1_oe_o);

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
   import dbg_entry_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PF_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bkpt_n_i,
   input  logic pipe_adv_i,
   input  logic fetch_tag_i,
   input  logic flush_i,
   input  logic op_bkpt_i,
   input  logic opfetch_i,
   input  logic bgnd_i,
   input  logic boundary_i,
   input  logic resume_i,
   input  logic ser_tx_i,
   input  logic trk1_i,
   output logic freeze_o,
   output logic exc_req_o,
   output logic trk0_o,
   output logic trk1_o,
   output logic trk1_oe_o,
   output logic ser_rx_o
);
   logic     en;
   logic     tag_ack;
   dbg_req_t req;

   dbg_enable_sample #(.SYNC_STAGES(SYNC_STAGES)) u_en (
      .clk(clk), .rst_n(rst_n), .bkpt_n_i(bkpt_n_i), .en_o(en));

   dbg_tag_pipe #(.PF_STAGES(PF_STAGES)) u_tags (
      .clk(clk), .rst_n(rst_n), .adv_i(pipe_adv_i), .tag_i(fetch_tag_i),
      .flush_i(flush_i), .ack_o(tag_ack));

   assign req.tag_ack = tag_ack;
   assign req.operand = op_bkpt_i;
   assign req.bgnd    = bgnd_i;

   dbg_freeze_ctl u_frz (
      .clk(clk), .rst_n(rst_n), .en_i(en), .req_i(req),
      .boundary_i(boundary_i), .resume_i(resume_i),
      .freeze_o(freeze_o), .exc_o(exc_req_o));

   dbg_track_mux u_trk (
      .clk(clk), .rst_n(rst_n), .freeze_i(freeze_o), .adv_i(pipe_adv_i),
      .opfetch_i(opfetch_i), .ser_tx_i(ser_tx_i), .trk1_i(trk1_i),
      .trk0_o(trk0_o), .trk1_o(trk1_o), .trk1_oe_o(trk1_oe_o),
      .ser_rx_o(ser_rx_o));

endmodule

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 3;
   localparam int PF   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0, bkpt_n = 1'b1, adv = 0, ftag = 0, flush = 0, opb = 0;
   logic opf = 0, bgnd = 0, bnd = 0, resume = 0, stx = 0, t1i = 0;
   logic freeze, exc, trk0, trk1, trk1_oe, srx;

   int n_checks = 0, n_errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_entry_ctrl #(.SYNC_STAGES(SYNC), .PF_STAGES(PF)) u_dbg_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .bkpt_n_i(bkpt_n), .pipe_adv_i(adv),
      .fetch_tag_i(ftag), .flush_i(flush), .op_bkpt_i(opb), .opfetch_i(opf),
      .bgnd_i(bgnd), .boundary_i(bnd), .resume_i(resume), .ser_tx_i(stx),
      .trk1_i(t1i), .freeze_o(freeze), .exc_req_o(exc), .trk0_o(trk0),
      .trk1_o(trk1), .trk1_oe_o(trk1_oe), .ser_rx_o(srx));

   // ---------------- behavioural reference model ----------------
   bit m_en, m_frz, m_exc, m_pd, m_pe, m_adv, m_of;
   bit pins[$];
   bit tags[$];

   initial begin
      for (int i = 0; i < SYNC; i++) pins.push_back(1'b1);
      for (int i = 0; i < PF; i++) tags.push_back(1'b0);
   end

   always @(posedge clk) begin
      bit old_pin, ack, any, wd, we, td, te;
      old_pin = pins[pins.size() - SYNC];
      pins.push_back(bkpt_n);
      if (pins.size() > 16) void'(pins.pop_front());
      if (!rst_n) begin
         m_en = !old_pin;
         m_frz = 0; m_exc = 0; m_pd = 0; m_pe = 0; m_adv = 0; m_of = 0;
         tags = {};
         for (int i = 0; i < PF; i++) tags.push_back(1'b0);
      end else begin
         ack = adv && tags[PF-1] && !flush;
         if (flush) begin
            for (int i = 0; i < PF; i++) tags[i] = 1'b0;
         end else if (adv) begin
            void'(tags.pop_back());
            tags.push_front(ftag);
         end
         any = ack || opb;
         wd = m_en && !m_frz && (any || bgnd);
         we = !m_en && any;
         td = !m_frz && bnd && (m_pd || wd);
         te = bnd && (m_pe || we);
         m_exc = te;
         m_pe = te ? 0 : (m_pe || we);
         if (m_frz) begin
            m_pd = 0;
            if (resume) m_frz = 0;
         end else begin
            m_pd = td ? 0 : (m_pd || wd);
            if (td) m_frz = 1;
         end
         m_adv = adv; m_of = opf;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(freeze == m_frz, "R7 freeze_o", freeze, m_frz);
      chk(exc == m_exc, "R8 exc_req_o", exc, m_exc);
      chk(trk0 == (m_frz ? stx : m_adv), "R9 trk0_o", trk0, m_frz ? stx : m_adv);
      chk(trk1 == (m_frz ? 1'b0 : m_of), "R9 trk1_o", trk1, m_frz ? 0 : m_of);
      chk(trk1_oe == !m_frz, "R9 trk1_oe_o", trk1_oe, !m_frz);
      chk(srx == (m_frz ? t1i : 1'b0), "R9 ser_rx_o", srx, m_frz ? t1i : 0);
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      adv = 0; ftag = 0; flush = 0; opb = 0; opf = 0; bgnd = 0;
      bnd = 0; resume = 0; stx = 0; t1i = 0;
   endtask

   // reset for `total` edges, pin low on the last `low` of them
   task automatic do_reset(input int total, input int low);
      idle();
      rst_n = 0;
      for (int i = 0; i < total; i++) begin
         bkpt_n = (i >= total - low) ? 1'b0 : 1'b1;
         tick();
      end
      rst_n = 1; bkpt_n = 1;
   endtask

   // probe the enable via bgnd at a boundary; expect freeze or not, then leave
   task automatic probe_enable(input bit exp, input string req);
      bgnd = 1; bnd = 1; tick(); idle();
      chk(freeze == exp, req, freeze, exp);
      chk(exc == 0, "R8 bgnd raises no exception", exc, 0);
      resume = 1; tick(); idle();
      chk(freeze == 0, "R10 resume", freeze, 0);
   endtask

   task automatic random_phase(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         adv = $urandom_range(0, 1); ftag = $urandom_range(0, 3) == 0;
         flush = $urandom_range(0, 7) == 0; opb = $urandom_range(0, 15) == 0;
         opf = $urandom_range(0, 1); bgnd = $urandom_range(0, 15) == 0;
         bnd = $urandom_range(0, 2) == 0; resume = $urandom_range(0, 9) == 0;
         stx = $urandom_range(0, 1); t1i = $urandom_range(0, 1);
         tick();
      end
      idle();
   endtask

   initial begin
      // ---- enabled ----
      do_reset(10, 8);
      chk(freeze == 0 && exc == 0, "R9 reset state freeze/exc", freeze, 0);
      chk(trk1_oe == 1, "R9 reset state trk1_oe_o", trk1_oe, 1);
      probe_enable(1, "R1 enable captured low pin");

      // R9 serial role while frozen
      opb = 1; bnd = 1; tick(); idle();
      chk(freeze == 1, "R6 operand breakpoint enters", freeze, 1);
      stx = 1; t1i = 1; #1;
      chk(trk0 == 1 && srx == 1 && trk1_oe == 0, "R9 serial role", {trk0, srx, trk1_oe}, 3'b110);
      stx = 0; t1i = 0;
      bgnd = 1; bnd = 1; tick(); idle();
      resume = 1; tick(); idle();
      tick();
      chk(freeze == 0, "R10 request while frozen dropped", freeze, 0);

      // R4 tag reaches execute with boundary late
      adv = 1; ftag = 1; tick();
      ftag = 0; tick();
      tick(); idle();
      chk(freeze == 0, "R7 waits for boundary", freeze, 0);
      bnd = 1; tick(); idle();
      chk(freeze == 1, "R4 tag acknowledged at stage exit", freeze, 1);
      resume = 1; tick(); idle();

      // R5 flush colliding with advance drops the tag
      adv = 1; ftag = 1; bnd = 1; tick();
      ftag = 0; tick();
      flush = 1; tick(); flush = 0;
      tick(); tick(); idle();
      chk(freeze == 0, "R5 flushed tag not acknowledged", freeze, 0);

      resume = 1; tick(); idle();
      chk(freeze == 0, "R10 resume ignored when running", freeze, 0);
      random_phase(3000);

      // ---- disabled ----
      do_reset(10, 0);
      probe_enable(0, "R2 high pin disables");
      opb = 1; tick(); idle(); tick();
      chk(exc == 0, "R8 exception waits for boundary", exc, 0);
      bnd = 1; tick(); idle();
      chk(exc == 1, "R8 exception pulse", exc, 1);
      tick();
      chk(exc == 0, "R8 pulse one cycle", exc, 0);
      random_phase(3000);

      // ---- too-short pin pulse ----
      do_reset(10, SYNC);
      probe_enable(0, "R3 short pulse not captured");
      do_reset(10, SYNC + 1);
      probe_enable(1, "R3 minimum pulse captured");
      random_phase(2000);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule